// File: doc/BRIEF.md
# Comparator Window Limit Checker

This block is a small test sequencer that decides whether an analog input voltage sits inside a window without performing a full successive-approximation conversion. A test controller supplies a lower and an upper 10-bit limit code and pulses a start strobe. The block then drives the converter's DAC code, controls the sample/hold line, and reads the comparator output back. It reports a one-bit verdict together with a completion flag.

A run has three phases. First the block samples with the hold line low and the DAC parked at mid-scale. Next it holds and presents the lower limit, expecting the comparator to read low. Finally it presents the upper limit, expecting the comparator to read high. The converter enable input has a settling delay: the hold line cannot rise until the enable has been high for a fixed time, given in picoseconds and converted to clock cycles. If the converter is disabled during a run, the run is aborted. Limits given in the wrong order are rejected before anything is driven.

Top module: `bracket_probe`

## Requirements
- R1: After reset, `done` and `pass` are 0, `hold_n_sample` is 0 and `dac_code` is 10'h200.
- R2: Whenever `hold_n_sample` is 0 (sample phase), `dac_code` equals the mid-scale code 10'h200.
- R3: `hold_n_sample` rises only after `conv_en` has been high for at least EN_WAIT_CYC consecutive cycles, where EN_WAIT_CYC = ceil(EN_WAIT_PS / CLK_PERIOD_PS) (10 at the defaults). A start accepted while the wait is still running stays in the sample phase until the wait ends.
- R4: After an accepted start with lower ≤ upper, the sample phase lasts at least SAMPLE_CYC cycles (3). Then `dac_code` shows the lower limit with `hold_n_sample` high for SETTLE_CYC cycles (4), and `cmp_out` is sampled on the last of those cycles.
- R5: If `cmp_out` is 1 at the lower-limit sample, the run ends with `done`=1 and `pass`=0, and the upper limit is never driven. At the defaults, `done` rises 8 cycles after the start edge.
- R6: Otherwise `dac_code` shows the upper limit for SETTLE_CYC cycles with `hold_n_sample` high, and `pass` takes the value of `cmp_out` on the last of those cycles. At the defaults, `done` rises 12 cycles after the start edge.
- R7: A start with lower > upper gives `done`=1 and `pass`=0 on the next cycle, and `hold_n_sample` stays 0.
- R8: `done` and `pass` keep their value until the next accepted start. An accepted start clears `done` on the following cycle unless R7 applies.
- R9: A start strobe that arrives while a run is in progress is ignored. The limits and the result of that run are unchanged.
- R10: If `conv_en` is 0 while a limit is being driven, the run is aborted: the next cycle shows `done`=1, `pass`=0 and `hold_n_sample`=0. The abort takes precedence over a comparator sample that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_en | input | 1 | Converter enable; its rising edge starts the settling wait |
| start | input | 1 | One-cycle request to run a window check |
| lo_limit | input | 10 | Lower limit code, captured on an accepted start |
| hi_limit | input | 10 | Upper limit code, captured on an accepted start |
| cmp_out | input | 1 | Comparator result, 1 when the DAC code is above the input |
| dac_code | output | 10 | Code driven to the converter DAC |
| hold_n_sample | output | 1 | 1 = hold (limit applied), 0 = sample (mid-scale) |
| done | output | 1 | Run finished; stays valid until the next accepted start |
| pass | output | 1 | Verdict of the last run, valid while done is 1 |

## Verification
Two events can fall in the same cycle: the loss of `conv_en`, and the comparator sample at the end of the upper-limit dwell. The bench sets up an input inside the window, so the run would pass, and drops the enable exactly before the edge on which the upper sample is taken. It expects an aborted run with a fail verdict, with hold released on the next cycle. The bench also sweeps a grid of limit pairs against several input levels. Its comparator model only follows the DAC after a lag of SETTLE_CYC-1 cycles, so a shortened dwell gives a wrong verdict.

// File: rtl/bp_pkg.sv
// Package for the window limit checker: sequencer state encoding and
// a helper that gives the mid-scale code for a DAC width.
package bp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } bp_state_t;

    // Mid-scale code: only the most significant bit set.
    function automatic logic [15:0] mid_code(input int w);
        logic [15:0] r;
        r = '0;
        r[w-1] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/bp_enable_timer.sv
// Enable settling timer.
// Counts consecutive cycles with the converter enable high and raises
// `ready` once WAIT_CYC cycles have passed. It restarts whenever the
// enable is low.
// Assumes: conv_en is synchronous to clk.
module bp_enable_timer #(
    parameter int WAIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_en,
    output logic ready
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC);

    logic [CW-1:0] cnt;

    // Count enabled cycles, saturating at the wait length.
    always_ff @(posedge clk) begin
        if (!rst_n || !conv_en) cnt <= '0;
        else if (cnt != LAST)   cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LAST);
endmodule

// File: rtl/bp_dwell.sv
// Dwell counter.
// Counts cycles spent in the current phase, saturating at `term`, and
// flags the cycle in which the count equals `term`. Clearing it puts
// the count back to zero for the next phase.
// Assumes: term is stable while the counter is not being cleared.
module bp_dwell #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] term,
    output logic             at_term
);
    logic [CNT_W-1:0] cnt;

    // Advance the phase count; hold at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (!at_term)  cnt <= cnt + 1'b1;
    end

    assign at_term = (cnt == term);
endmodule

// File: rtl/bp_seq.sv
// Window check sequencer.
// Phases: sample at mid-scale, hold with the lower limit, then hold
// with the upper limit. The lower check trips on a high comparator and
// skips the upper check. Limits in the wrong order are rejected at
// start. Losing the enable while a limit is driven aborts the run.
// Assumes: cmp_out is already synchronous to clk.
module bp_seq #(
    parameter int DAC_W      = 10,
    parameter int SAMPLE_CYC = 3,
    parameter int SETTLE_CYC = 4,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_en,
    input  logic             en_ready,
    input  logic             start,
    input  logic [DAC_W-1:0] lo_limit,
    input  logic [DAC_W-1:0] hi_limit,
    input  logic             cmp_out,
    input  logic             at_term,
    output logic             dwell_clr,
    output logic [CNT_W-1:0] dwell_term,
    output logic             busy,
    output logic [DAC_W-1:0] dac_code,
    output logic             hold_n_sample,
    output logic             done,
    output logic             pass
);
    import bp_pkg::*;

    localparam logic [DAC_W-1:0] MID = DAC_W'(mid_code(DAC_W));
    localparam logic [CNT_W-1:0] SAMP_LAST   = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    bp_state_t        st, nxt;
    logic [DAC_W-1:0] lo_q, hi_q;
    logic             accept, bad_order, finish, verdict;

    assign accept    = (st == ST_IDLE) && start;
    assign bad_order = lo_limit > hi_limit;

    // Next-state and completion decision for each phase.
    always_comb begin
        nxt     = st;
        finish  = 1'b0;
        verdict = 1'b0;
        unique case (st)
            ST_IDLE: if (accept && !bad_order) nxt = ST_SAMP;
            ST_SAMP: if (at_term && en_ready) nxt = ST_LOW;
            ST_LOW: begin
                if (!conv_en) begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                end else if (at_term) begin
                    if (cmp_out) begin
                        finish = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        nxt = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (!conv_en) begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                end else if (at_term) begin
                    finish  = 1'b1;
                    verdict = cmp_out;
                    nxt     = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Capture the limits when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= lo_limit;
            hi_q <= hi_limit;
        end
    end

    // Result flags: cleared or set by a start, set at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else if (accept) begin
            done <= bad_order;
            pass <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
            pass <= verdict;
        end
    end

    // Dwell control: restart on every phase change, pick the phase length.
    assign dwell_clr  = (nxt != st) || (st == ST_IDLE);
    assign dwell_term = (st == ST_SAMP) ? SAMP_LAST : SETTLE_LAST;

    // Converter drive: a limit during hold phases, mid-scale otherwise.
    always_comb begin
        unique case (st)
            ST_LOW:  begin dac_code = lo_q; hold_n_sample = 1'b1; end
            ST_HIGH: begin dac_code = hi_q; hold_n_sample = 1'b1; end
            default: begin dac_code = MID;  hold_n_sample = 1'b0; end
        endcase
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/bracket_probe.sv
// Comparator window limit checker, top level.
// Brackets an analog input between two limit codes with two comparator
// checks instead of a full conversion. It enforces a settling wait after
// the converter is enabled and keeps mid-scale during sampling.
// Assumes: EN_WAIT_PS and CLK_PERIOD_PS are positive; SAMPLE_CYC and
// SETTLE_CYC are at least 1.
module bracket_probe #(
    parameter int DAC_W         = 10,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int EN_WAIT_PS    = 200000,
    parameter int SAMPLE_CYC    = 3,
    parameter int SETTLE_CYC    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_en,
    input  logic             start,
    input  logic [DAC_W-1:0] lo_limit,
    input  logic [DAC_W-1:0] hi_limit,
    input  logic             cmp_out,
    output logic [DAC_W-1:0] dac_code,
    output logic             hold_n_sample,
    output logic             done,
    output logic             pass
);
    localparam int EN_WAIT_CYC = (EN_WAIT_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int MAX_DWELL   = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
    localparam int CNT_W       = $clog2(MAX_DWELL + 1);

    logic             en_ready;
    logic             dwell_clr;
    logic             at_term;
    logic [CNT_W-1:0] dwell_term;
    logic             seq_busy;

    bp_enable_timer #(.WAIT_CYC(EN_WAIT_CYC)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .conv_en (conv_en),
        .ready   (en_ready)
    );

    bp_dwell #(.CNT_W(CNT_W)) i_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dwell_clr),
        .term    (dwell_term),
        .at_term (at_term)
    );

    bp_seq #(
        .DAC_W      (DAC_W),
        .SAMPLE_CYC (SAMPLE_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CNT_W      (CNT_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_en       (conv_en),
        .en_ready      (en_ready),
        .start         (start),
        .lo_limit      (lo_limit),
        .hi_limit      (hi_limit),
        .cmp_out       (cmp_out),
        .at_term       (at_term),
        .dwell_clr     (dwell_clr),
        .dwell_term    (dwell_term),
        .busy          (seq_busy),
        .dac_code      (dac_code),
        .hold_n_sample (hold_n_sample),
        .done          (done),
        .pass          (pass)
    );
endmodule

// File: rtl/bp_checker.sv
// Property checker for the window limit checker, bound to the top.
// Keeps its own count of enabled cycles to judge the settling rule.
module bp_checker #(
    parameter int DAC_W       = 10,
    parameter int EN_WAIT_CYC = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_en,
    input logic             start,
    input logic [DAC_W-1:0] lo_limit,
    input logic [DAC_W-1:0] hi_limit,
    input logic [DAC_W-1:0] dac_code,
    input logic             hold_n_sample,
    input logic             done,
    input logic             pass,
    input logic             seq_busy
);
    localparam int CW = $clog2(EN_WAIT_CYC + 1);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    logic [CW-1:0] en_cycles;

    // Independent count of consecutive enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !conv_en)               en_cycles <= '0;
        else if (en_cycles != CW'(EN_WAIT_CYC)) en_cycles <= en_cycles + 1'b1;
    end

    AST_MID_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n_sample |-> dac_code == MID) else $error("mid-scale lost");  // R2

    AST_HOLD_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n_sample |-> en_cycles == CW'(EN_WAIT_CYC)) else $error("early hold");  // R3

    AST_REVERSED_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !seq_busy && (lo_limit > hi_limit) |=> done && !pass && !hold_n_sample) else $error("bad order");  // R7

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(pass)) else $error("result moved");  // R8

    AST_ABORT_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> !hold_n_sample) else $error("hold kept");  // R10

    AST_ABORT_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n_sample && !conv_en |=> done && !pass) else $error("abort verdict");  // R10
endmodule

bind bracket_probe bp_checker #(.DAC_W(DAC_W), .EN_WAIT_CYC(EN_WAIT_CYC)) i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_en       (conv_en),
    .start         (start),
    .lo_limit      (lo_limit),
    .hi_limit      (hi_limit),
    .dac_code      (dac_code),
    .hold_n_sample (hold_n_sample),
    .done          (done),
    .pass          (pass),
    .seq_busy      (seq_busy)
);

// File: tb/test_bracket_probe.sv
`timescale 1ns/1ps
module test_bracket_probe;
    localparam int W       = 10;
    localparam int SAMPLE  = 3;
    localparam int SETTLE  = 4;
    localparam int EN_WAIT = (200000 + 20000 - 1) / 20000;
    localparam logic [W-1:0] MID = 10'h200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] lo_limit = '0;
    logic [W-1:0] hi_limit = '0;
    logic [W-1:0] vin = '0;
    logic         cmp_out;
    logic [W-1:0] dac_code;
    logic         hold_n_sample, done, pass;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Comparator model: follows the DAC after SETTLE-1 cycles of lag.
    logic [W-1:0] lag [SETTLE-1];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETTLE-1; i++) lag[i] <= MID;
        end else begin
            lag[0] <= dac_code;
            for (int i = 1; i < SETTLE-1; i++) lag[i] <= lag[i-1];
        end
    end
    assign cmp_out = lag[SETTLE-2] > vin;

    bracket_probe i_bracket_probe (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .start(start),
        .lo_limit(lo_limit), .hi_limit(hi_limit), .cmp_out(cmp_out),
        .dac_code(dac_code), .hold_n_sample(hold_n_sample),
        .done(done), .pass(pass)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One window check; returns after done is seen or a timeout.
    task automatic run_case(input logic [W-1:0] lo, input logic [W-1:0] hi,
                            input logic [W-1:0] v);
        int exp_lat, lat, holds, bad_dac;
        bit exp_pass;
        lo_limit = lo; hi_limit = hi; vin = v; start = 1'b1;
        tick();
        start = 1'b0;
        if (lo > hi)      begin exp_lat = 1; exp_pass = 0; end
        else if (lo > v)  begin exp_lat = 1 + SAMPLE + SETTLE; exp_pass = 0; end
        else              begin exp_lat = 1 + SAMPLE + 2*SETTLE; exp_pass = (hi > v); end
        lat = 0; holds = 0; bad_dac = 0;
        for (int n = 1; n <= 40; n++) begin
            if (!hold_n_sample && dac_code != MID) bad_dac++;          // R2
            if (hold_n_sample) begin
                if (dac_code != ((holds < SETTLE) ? lo : hi)) bad_dac++;
                holds++;
            end
            if (done) begin lat = n; break; end
            tick();
        end
        chk(lat == exp_lat, (lo > hi) ? "R7 latency" : (lo > v) ? "R5 latency" : "R6 latency", lat, exp_lat);
        chk(pass == exp_pass, (lo > hi) ? "R7 verdict" : (lo > v) ? "R5 verdict" : "R6 verdict", pass, exp_pass);
        chk(holds == ((lo > hi) ? 0 : (lo > v) ? SETTLE : 2*SETTLE), "R4 hold cycles", holds,
            (lo > hi) ? 0 : (lo > v) ? SETTLE : 2*SETTLE);
        chk(bad_dac == 0, "R2/R4 dac code", bad_dac, 0);
    endtask

    function automatic logic [W-1:0] pick(input int i);
        case (i)
            0: return 10'h000;
            1: return 10'h001;
            2: return 10'h1FF;
            3: return 10'h200;
            4: return 10'h3FE;
            default: return 10'h3FF;
        endcase
    endfunction

    initial begin : main
        int rise;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(done == 0 && pass == 0, "R1 flags", {done, pass}, 0);
        chk(hold_n_sample == 0 && dac_code == MID, "R1 drive", dac_code, MID);

        // R3: start while disabled, then enable; hold waits out the settling time.
        lo_limit = 10'h100; hi_limit = 10'h300; vin = 10'h200; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(!hold_n_sample, "R3 no hold while disabled", hold_n_sample, 0);
            tick();
        end
        conv_en = 1'b1;
        rise = 0;
        for (int n = 1; n <= 40; n++) begin
            tick();
            if (hold_n_sample) begin rise = n; break; end
        end
        chk(rise == EN_WAIT + 1, "R3 settling wait", rise, EN_WAIT + 1);
        while (!done) tick();
        chk(pass == 1, "R3 run after wait", pass, 1);

        // R8: result holds while the comparator input moves.
        for (int i = 0; i < 5; i++) begin
            vin = 10'(i * 200);
            tick();
            chk(done == 1 && pass == 1, "R8 result held", {done, pass}, 3);
        end

        // Sweep of limit pairs against input levels (R4 R5 R6 R7).
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    run_case(pick(a), pick(b), pick(c));

        // R8: an accepted start clears done on the next cycle.
        lo_limit = 10'h050; hi_limit = 10'h350; vin = 10'h100; start = 1'b1;
        tick();
        start = 1'b0;
        chk(done == 0, "R8 start clears done", done, 0);
        // R9: a start mid-run with reversed limits is ignored.
        repeat (4) tick();
        lo_limit = 10'h3FF; hi_limit = 10'h000; start = 1'b1;
        tick();
        start = 1'b0;
        chk(done == 0, "R9 busy start ignored", done, 0);
        for (int n = 6; n <= 40 && !done; n++) begin
            if (hold_n_sample && dac_code != 10'h050 && dac_code != 10'h350)
                chk(0, "R9 limits kept", dac_code, 10'h050);
            tick();
        end
        chk(pass == 1, "R9 verdict kept", pass, 1);

        // R10: disable lands on the same cycle as the upper sample.
        lo_limit = 10'h100; hi_limit = 10'h300; vin = 10'h200; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (1 + SAMPLE + 2*SETTLE - 2) tick();
        chk(hold_n_sample == 1 && done == 0, "R10 still in upper phase", hold_n_sample, 1);
        conv_en = 1'b0;
        tick();
        chk(done == 1 && pass == 0, "R10 abort verdict", {done, pass}, 2);
        chk(hold_n_sample == 0 && dac_code == MID, "R10 hold released", hold_n_sample, 0);

        // R10: disable during the lower phase.
        conv_en = 1'b1;
        repeat (EN_WAIT + 2) tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        repeat (SAMPLE + 1) tick();
        chk(hold_n_sample == 1, "R10 lower phase reached", hold_n_sample, 1);
        conv_en = 1'b0;
        tick();
        chk(done == 1 && pass == 0 && hold_n_sample == 0, "R10 abort in lower phase",
            {done, pass, hold_n_sample}, 4);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule